// File: doc/BRIEF.md
# SPI Baud Divisor Search Engine

This sequential unit turns a core clock frequency and a requested SPI bit rate, both given in Hz, into the 8-bit prescale field that an SPI clock prescaler is loaded with. It serves two prescaler formats. The legacy format takes a single even divisor between 4 and 30. The extended format takes a 4-bit linear factor and a 3-bit power-of-two exponent.

In the extended format the engine tries all eight exponents in turn. For each one it works out the smallest linear factor that does not exceed the requested rate, computes the rate that setting actually gives, and keeps the candidate that comes closest to the request from below. In the legacy format it computes the rounded-up even divisor directly.

All quotients come from a single restoring divider that produces one quotient bit per clock. A caller pulses `start` with the operands held on the inputs, waits for the one-cycle `done` pulse, and then reads `prescale` and `error`.

Top module: `spi_baud_search`

## Requirements
- R1: Extended format. For each exponent p from 0 to 7 the factor is k = ceil(floor(fclk / 2^p) / speed). A candidate whose k is 0 or above 15 is not considered.
- R2: Extended format. The achieved rate of a candidate is floor(fclk / (k * 2^p)), and its error is speed minus that rate. The running best error starts at speed. A candidate replaces the best only when its error is strictly smaller, so on a tie the lower exponent is kept.
- R3: Extended format. The result is packed as follows: bits [3:0] hold k; bit 4 holds p[0]; bit 5 is 0; bits [7:6] hold p[2:1].
- R4: Extended format. If no candidate was ever accepted (best k and best p both 0), `error` is 1 and `prescale` is 0.
- R5: Legacy format. The divisor is d = ceil(fclk / speed), rounded up to the next even value and raised to 4 if it is below 4. The result is 0x10 + d/2.
- R6: Legacy format. If the even divisor exceeds 30, `error` is 1 and `prescale` is 0.
- R7: A requested speed of 0 gives `error` = 1, `prescale` = 0 and `done` in the cycle after `start`, with no search and no `busy`.
- R8: `busy` is high while a computation runs. `done` is a one-cycle pulse given when `busy` falls, and never while `busy` is high.
- R9: A `start` that arrives while `busy` is high is ignored. The running computation finishes on its original operands.
- R10: `prescale` and `error` hold their values from the end of one computation until the next accepted `start`.
- R11: After reset, `busy`, `done` and `error` are 0 and `prescale` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation; sampled only when idle |
| fclk_hz | input | W | Core clock frequency in Hz |
| speed_hz | input | W | Requested SPI rate in Hz |
| ext_fmt | input | 1 | 1 selects the extended format, 0 the legacy format |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| error | output | 1 | The request cannot be met |
| prescale | output | 8 | Packed prescale field |

## Verification
The bench builds the block with W = 16. At that width the operands are small enough to sweep a grid of clock frequencies against requested rates in both formats, and each run still stays short. The grid reaches every branch of the design: candidates rejected because k is too large, candidates rejected because k is 0, ties settled in favour of the lower exponent, the top exponent 7 being packed, the legacy divisor clamped to 4, and the legacy divisor exceeding 30. A dense run of requested rates against a single legacy clock sweeps every even divisor in turn, and separate directed cases cover a zero request, a start given while busy, and holding of the result after it is delivered.

// File: rtl/spi_baud_search.sv
module spi_baud_search #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] fclk_hz,
  input  logic [W-1:0] speed_hz,
  input  logic         ext_fmt,
  output logic         busy,
  output logic         done,
  output logic         error,
  output logic [7:0]   prescale
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [2:0] {S_IDLE, S_DIV1, S_EVAL1, S_DIV2, S_EVAL2} st_t;

  st_t           st;
  logic [W-1:0]  f_q, sp_q;
  logic          ext_q;
  logic [2:0]    exp_q, best_exp;
  logic [3:0]    fac_q, best_fac;
  logic [W-1:0]  best_err;
  logic [W-1:0]  quo, rem, dvs;
  logic [CW-1:0] cnt;

  // one quotient bit per cycle
  logic [W:0]   trial;
  logic         fits;
  assign trial = {rem, quo[W-1]};
  assign fits  = trial >= {1'b0, dvs};

  logic [W:0]   ceil_q;
  logic [W+1:0] even_d;
  logic [5:0]   clamp_d;
  logic [W-1:0] cand_err;
  logic         last_exp;
  logic [2:0]   next_exp;
  logic [7:0]   packed_ps;

  assign ceil_q    = {1'b0, quo} + {{W{1'b0}}, (rem != '0)};
  assign even_d    = {1'b0, ceil_q} + {{(W+1){1'b0}}, ceil_q[0]};
  assign clamp_d   = (even_d < 4) ? 6'd4 : even_d[5:0];
  assign cand_err  = sp_q - quo;
  assign last_exp  = (exp_q == 3'd7);
  assign next_exp  = exp_q + 3'd1;
  assign packed_ps = {best_exp[2:1], 1'b0, best_exp[0], best_fac};
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  f_q <= '0;  sp_q <= '0;  ext_q <= 1'b0;
      exp_q <= '0;  fac_q <= '0;  best_exp <= '0;  best_fac <= '0;
      best_err <= '0;  quo <= '0;  rem <= '0;  dvs <= '0;  cnt <= '0;
      done <= 1'b0;  error <= 1'b0;  prescale <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          f_q <= fclk_hz;  sp_q <= speed_hz;  ext_q <= ext_fmt;
          if (speed_hz == '0) begin
            error <= 1'b1;  prescale <= '0;  done <= 1'b1;
          end else begin
            exp_q <= '0;  best_exp <= '0;  best_fac <= '0;  best_err <= speed_hz;
            quo <= fclk_hz;  rem <= '0;  dvs <= speed_hz;  cnt <= '0;
            st <= S_DIV1;
          end
        end
        S_DIV1, S_DIV2: begin
          quo <= {quo[W-2:0], fits};
          rem <= fits ? W'(trial - {1'b0, dvs}) : trial[W-1:0];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= (st == S_DIV1) ? S_EVAL1 : S_EVAL2;
        end
        S_EVAL1: begin
          if (!ext_q) begin
            st <= S_IDLE;  done <= 1'b1;
            if (even_d > 30) begin
              error <= 1'b1;  prescale <= '0;
            end else begin
              error <= 1'b0;  prescale <= 8'h10 + {3'b0, clamp_d[5:1]};
            end
          end else if (ceil_q == '0 || ceil_q > 15) begin
            if (last_exp) begin
              st <= S_IDLE;  done <= 1'b1;
              error <= (best_fac == '0 && best_exp == '0);
              prescale <= (best_fac == '0 && best_exp == '0) ? 8'h00 : packed_ps;
            end else begin
              exp_q <= next_exp;  quo <= f_q >> next_exp;  rem <= '0;
              dvs <= sp_q;  cnt <= '0;  st <= S_DIV1;
            end
          end else begin
            fac_q <= ceil_q[3:0];
            quo <= f_q;  rem <= '0;  dvs <= W'(ceil_q[3:0]) << exp_q;
            cnt <= '0;  st <= S_DIV2;
          end
        end
        S_EVAL2: begin
          if (last_exp) begin
            st <= S_IDLE;  done <= 1'b1;
            if (cand_err < best_err) begin
              error <= 1'b0;
              prescale <= {exp_q[2:1], 1'b0, exp_q[0], fac_q};
            end else begin
              error <= (best_fac == '0 && best_exp == '0);
              prescale <= (best_fac == '0 && best_exp == '0) ? 8'h00 : packed_ps;
            end
          end else begin
            if (cand_err < best_err) begin
              best_err <= cand_err;  best_fac <= fac_q;  best_exp <= exp_q;
            end
            exp_q <= next_exp;  quo <= f_q >> next_exp;  rem <= '0;
            dvs <= sp_q;  cnt <= '0;  st <= S_DIV1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R8
  AST_ZERO_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && speed_hz == '0) |=> (done && error && !busy));  // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(prescale) && $stable(error)));  // R10
  AST_LEGACY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error && !ext_q) |-> (prescale >= 8'h12 && prescale <= 8'h1F));  // R5
  AST_EXT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error && ext_q) |-> (prescale[5] == 1'b0 && prescale[3:0] != 4'd0));  // R3
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (prescale == 8'h00));  // R4
endmodule

// File: tb/sim_spi_baud_search.sv
module sim_spi_baud_search;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] fclk_hz = '0;
  logic [W-1:0] speed_hz = '0;
  logic         ext_fmt = 1'b0;
  logic         busy, done, error;
  logic [7:0]   prescale;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  spi_baud_search #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fclk_hz(fclk_hz),
    .speed_hz(speed_hz), .ext_fmt(ext_fmt), .busy(busy), .done(done),
    .error(error), .prescale(prescale)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: got running, expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests = tests + 1;
    if (got !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: got %0h, expected %0h", tag, got, exp);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 computed arithmetically
  task automatic model(input longint f, input longint s, input bit ext,
                       output bit e, output logic [7:0] ps);
    longint best, q, k, r, d;
    int bk, bp;
    e = 0; ps = 0;
    if (s == 0) begin e = 1; return; end
    if (ext) begin
      best = s; bk = 0; bp = 0;
      for (int p = 0; p < 8; p++) begin
        q = f >> p;
        k = (q + s - 1) / s;
        if (k == 0 || k > 15) continue;
        r = f / (k << p);
        if (s - r < best) begin best = s - r; bk = int'(k); bp = p; end
      end
      if (bk == 0 && bp == 0) e = 1;
      else ps = 8'(((bp & 6) << 5) | ((bp & 1) << 4) | bk);
    end else begin
      d = (f + s - 1) / s;
      if (d % 2 == 1) d = d + 1;
      if (d > 30) e = 1;
      else begin
        if (d < 4) d = 4;
        ps = 8'(16 + d / 2);
      end
    end
  endtask

  task automatic kick(input longint f, input longint s, input bit ext);
    @(negedge clk);
    fclk_hz = W'(f); speed_hz = W'(s); ext_fmt = ext; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic run(input longint f, input longint s, input bit ext);
    bit e; logic [7:0] ps;
    model(f, s, ext, e, ps);
    kick(f, s, ext);
    wait_done();
    check(ext ? (e ? "R4" : "R2") : (e ? "R6" : "R5"), {31'b0, error}, {31'b0, e});
    check(ext ? "R1" : "R5", {24'b0, prescale}, {24'b0, ps});
    @(negedge clk);
    check("R8", {31'b0, done}, 32'd0);
  endtask

  initial begin
    longint fl[9] = '{0, 1, 7, 100, 1000, 4800, 9999, 50000, 65535};
    longint sl[12] = '{1, 2, 3, 5, 10, 17, 100, 333, 1000, 4096, 40000, 65535};
    bit e; logic [7:0] ps;

    repeat (3) @(negedge clk);
    check("R11", {28'b0, busy, done, error, 1'b0}, 32'd0);
    check("R11", {24'b0, prescale}, 32'd0);
    rst_n = 1'b1;

    // R3 directed packing: exponent 6, factor 11
    kick(65535, 100, 1'b1);
    check("R8", {31'b0, busy}, 32'd1);
    wait_done();
    check("R3", {24'b0, prescale}, 32'hCB);
    // R10 result held while idle
    repeat (6) @(negedge clk);
    check("R10", {23'b0, error, prescale}, 32'h0CB);

    // R7 zero request
    kick(1000, 0, 1'b1);
    check("R7", {30'b0, done, error}, 32'd3);
    check("R7", {31'b0, busy}, 32'd0);
    check("R7", {24'b0, prescale}, 32'd0);

    // R9 start ignored while busy
    kick(1000, 100, 1'b1);
    repeat (3) @(negedge clk);
    fclk_hz = 16'd50000; speed_hz = 16'd3; ext_fmt = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    model(1000, 100, 1'b1, e, ps);
    check("R9", {23'b0, error, prescale}, {23'b0, e, ps});

    foreach (fl[i]) foreach (sl[j]) begin
      run(fl[i], sl[j], 1'b1);
      run(fl[i], sl[j], 1'b0);
    end
    for (int s = 20; s < 600; s += 3) run(1000, s, 1'b0);
    for (int s = 1; s < 40; s++) run(6000, s * 97, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule